// File: doc/BRIEF.md
# Received-Signal Strength to Energy and Link-Quality Converter

This block takes the 8-bit signal-strength code from a 2.4 GHz radio receiver and turns it into one of the two 8-bit figures a low-rate wireless MAC reports upward. The first is the energy-detect figure used during channel scans. The second is the link-quality figure attached to each received frame. It also gives the signal strength as a signed dBm byte.

While an energy scan is running, the block keeps the largest energy figure seen so far. That figure only grows, and only from scans that ended successfully and gave a nonzero result. A one-cycle clear pulse starts a new scan session.

The raw code is an inverted dBm scale. Code 0x7F means 0 dBm and lower codes step down 1 dB each. A set top bit marks an unusable code. Each mode clips the dBm value to its own window and then scales it by a small integer, so the window fills the 0x00..0xFF output range.

Top module: `rssi_quality_conv`

## Requirements
- R1: When bit 7 of the raw code is set, the sample is invalid: `out_code` becomes 0x00 and `out_dbm` becomes 0x80 (-128), in either mode.
- R2: For a valid code, `out_dbm` is raw[6:0] minus 127 in two's complement. Code 0x7F gives 0x00 (0 dBm) and code 0x00 gives 0x81 (-127 dBm).
- R3: With `mode_lqi` = 0 (energy mode), the dBm value is clamped to -75..-24 and `out_code` = (dBm + 75) × 5. -75 dBm or below gives 0x00, -74 gives 0x05 and -24 or above gives 0xFF.
- R4: With `mode_lqi` = 1 (link-quality mode), the dBm value is clamped to -85..-21 and `out_code` = (dBm + 85) × 4. -85 or below gives 0x00, -84 gives 0x04 and -22 gives 0xFC.
- R5: In link-quality mode, a clamped value of -21 dBm gives 0xFF and not the 9-bit result 0x100.
- R6: `peak_ed` changes only on a sample where all of these hold:
  - `sample_vld` = 1;
  - `mode_lqi` = 0;
  - `scan_ok` = 1;
  - the energy result is nonzero;
  - the energy result is above the held value.
  It then takes that result. Every other sample leaves it unchanged.
- R7: `peak_clr` sets `peak_ed` to 0x00 at the next edge. It wins over a qualifying sample in the same cycle.
- R8: `out_code` and `out_dbm` load at the clock edge where `sample_vld` is high. `out_vld` is high for exactly the cycle after each such edge. With no strobe, both results hold their value.
- R9: While `rst_n` is low at a clock edge, `out_code`, `out_dbm`, `out_vld` and `peak_ed` all become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_rssi | input | 8 | Raw signal-strength code from the receiver |
| mode_lqi | input | 1 | 0 = energy-detect scaling, 1 = link-quality scaling |
| sample_vld | input | 1 | Raw code is valid this cycle |
| scan_ok | input | 1 | The energy scan that produced this sample ended successfully |
| peak_clr | input | 1 | Start a new scan session by clearing the held peak |
| out_vld | output | 1 | One-cycle pulse marking fresh results |
| out_code | output | 8 | Converted energy or link-quality figure |
| out_dbm | output | 8 | Signed dBm value of the sample |
| peak_ed | output | 8 | Largest qualifying energy figure since the last clear |

## Verification
Every result has a latency of one register. `out_code`, `out_dbm`, `out_vld` and `peak_ed` all reflect a strobed sample after the first rising edge that sees it, and `out_vld` falls again one edge later. The bench drives inputs on the falling edge and reads results on the next falling edge, which is half a cycle after the loading edge. One further falling edge later it confirms that `out_vld` has dropped and that the results have held.

// File: rtl/rqc_pkg.sv
// Package: shared types and fixed scale constants of the signal-strength converter.
// Assumes the raw code carries a 7-bit magnitude where all ones means 0 dBm.
package rqc_pkg;
    localparam int RAW_W   = 8;
    localparam int MAG_W   = RAW_W - 1;
    localparam int TOP_MAG = (1 << MAG_W) - 1;   // magnitude meaning 0 dBm
    typedef logic [RAW_W-1:0] code_t;
    typedef logic [MAG_W-1:0] mag_t;
endpackage

// File: rtl/rqc_dbm_map.sv
// Module: maps the raw code to a validity flag, the magnitude field and a signed dBm byte.
// Assumes an invalid code reports the marker value -128 on the dBm output.
module rqc_dbm_map
    import rqc_pkg::*;
(
    input  code_t raw,
    output logic  invalid,
    output mag_t  mag,
    output code_t dbm
);
    localparam code_t TOP_C  = code_t'(TOP_MAG);
    localparam code_t MARK_C = code_t'(1 << MAG_W);

    // Split the raw code and convert the magnitude to dBm.
    always_comb begin
        invalid = raw[RAW_W-1];
        mag     = raw[MAG_W-1:0];
        dbm     = invalid ? MARK_C : ({1'b0, mag} - TOP_C);
    end
endmodule

// File: rtl/rqc_window_scale.sv
// Module: clamps the magnitude to a dBm window and scales the offset by 4 or 5.
// Assumes LO_DBM..HI_DBM lies within -127..0; results above 255 saturate to 0xFF.
module rqc_window_scale
    import rqc_pkg::*;
#(
    parameter int LO_DBM   = -75,
    parameter int HI_DBM   = -24,
    parameter bit ADD_SELF = 1'b1
)(
    input  mag_t  mag,
    output code_t code
);
    localparam int   PROD_W = RAW_W + 1;
    localparam mag_t LO_C   = mag_t'(LO_DBM + TOP_MAG);
    localparam mag_t HI_C   = mag_t'(HI_DBM + TOP_MAG);

    mag_t              clamped;
    mag_t              offset;
    logic [PROD_W-1:0] wide;
    logic [PROD_W-1:0] prod;

    // Hold the magnitude inside the window.
    always_comb begin
        if (mag < LO_C)      clamped = LO_C;
        else if (mag > HI_C) clamped = HI_C;
        else                 clamped = mag;
        offset = clamped - LO_C;
        wide   = {{(PROD_W-MAG_W){1'b0}}, offset};
    end

    // Pick the multiplier variant: x5 as (x<<2)+x, x4 as x<<2.
    generate
        if (ADD_SELF) begin : g_times5
            always_comb prod = (wide << 2) + wide;
        end else begin : g_times4
            always_comb prod = wide << 2;
        end
    endgenerate

    // Saturate the 9-bit product into the byte output.
    always_comb code = prod[PROD_W-1] ? {RAW_W{1'b1}} : prod[RAW_W-1:0];
endmodule

// File: rtl/rqc_peak_hold.sv
// Module: keeps the largest nonzero energy figure of a scan session.
// Assumes upd is already qualified by strobe, mode and scan success; clr wins over upd.
module rqc_peak_hold
    import rqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  upd,
    input  code_t val,
    output code_t peak
);
    // Clear, or raise the held value on a larger nonzero figure.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                        peak <= '0;
        else if (upd && val != '0 && val > peak) peak <= val;
    end
endmodule

// File: rtl/rssi_quality_conv.sv
// Module: top of the converter; selects the mode result and registers all outputs.
// Assumes one sample per strobe; outputs hold between strobes.
module rssi_quality_conv
    import rqc_pkg::*;
#(
    parameter int ED_LO_DBM  = -75,
    parameter int ED_HI_DBM  = -24,
    parameter int LQI_LO_DBM = -85,
    parameter int LQI_HI_DBM = -21
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] raw_rssi,
    input  logic       mode_lqi,
    input  logic       sample_vld,
    input  logic       scan_ok,
    input  logic       peak_clr,
    output logic       out_vld,
    output logic [7:0] out_code,
    output logic [7:0] out_dbm,
    output logic [7:0] peak_ed
);
    logic  invalid;
    mag_t  mag;
    code_t dbm_c;
    code_t ed_c;
    code_t lqi_c;
    code_t sel_c;
    logic  peak_upd;

    rqc_dbm_map u_map (
        .raw     (raw_rssi),
        .invalid (invalid),
        .mag     (mag),
        .dbm     (dbm_c)
    );

    rqc_window_scale #(.LO_DBM(ED_LO_DBM), .HI_DBM(ED_HI_DBM), .ADD_SELF(1'b1)) u_ed (
        .mag  (mag),
        .code (ed_c)
    );

    rqc_window_scale #(.LO_DBM(LQI_LO_DBM), .HI_DBM(LQI_HI_DBM), .ADD_SELF(1'b0)) u_lqi (
        .mag  (mag),
        .code (lqi_c)
    );

    // Choose the mode result and force zero on an invalid code.
    always_comb begin
        sel_c    = invalid ? '0 : (mode_lqi ? lqi_c : ed_c);
        peak_upd = sample_vld && !mode_lqi && scan_ok && !invalid;
    end

    // Register the results and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_code <= '0;
            out_dbm  <= '0;
        end else begin
            out_vld <= sample_vld;
            if (sample_vld) begin
                out_code <= sel_c;
                out_dbm  <= dbm_c;
            end
        end
    end

    rqc_peak_hold u_peak (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (peak_clr),
        .upd   (peak_upd),
        .val   (invalid ? code_t'(0) : ed_c),
        .peak  (peak_ed)
    );
endmodule

// File: rtl/rqc_checker.sv
// Module: temporal properties of the converter, attached to the top by bind.
// Assumes the default dBm windows (-75..-24 and -85..-21).
module rqc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] raw_rssi,
    input logic       mode_lqi,
    input logic       sample_vld,
    input logic       scan_ok,
    input logic       peak_clr,
    input logic       out_vld,
    input logic [7:0] out_code,
    input logic [7:0] out_dbm,
    input logic [7:0] peak_ed
);
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && raw_rssi[7]) |=> (out_code == 8'h00 && out_dbm == 8'h80)); // R1
    AST_ED_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && !mode_lqi && !raw_rssi[7] && raw_rssi[6:0] <= 7'd52) |=> (out_code == 8'h00)); // R3
    AST_LQI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && mode_lqi && !raw_rssi[7] && raw_rssi[6:0] >= 7'd106) |=> (out_code == 8'hFF)); // R5
    AST_PEAK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_clr) |=> (peak_ed >= $past(peak_ed))); // R6
    AST_PEAK_LQI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_clr && (!sample_vld || mode_lqi || !scan_ok)) |=> $stable(peak_ed)); // R6
    AST_PEAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        peak_clr |=> (peak_ed == 8'h00)); // R7
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> out_vld); // R8
    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld) |=> (!out_vld && $stable(out_code) && $stable(out_dbm))); // R8
endmodule

bind rssi_quality_conv rqc_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_rssi   (raw_rssi),
    .mode_lqi   (mode_lqi),
    .sample_vld (sample_vld),
    .scan_ok    (scan_ok),
    .peak_clr   (peak_clr),
    .out_vld    (out_vld),
    .out_code   (out_code),
    .out_dbm    (out_dbm),
    .peak_ed    (peak_ed)
);

// File: tb/rssi_quality_conv_tb_top.sv
// Bench: vector table for the conversions, then directed peak, latency and reset tests.
module rssi_quality_conv_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] raw_rssi = '0;
    logic       mode_lqi = 1'b0;
    logic       sample_vld = 1'b0;
    logic       scan_ok = 1'b0;
    logic       peak_clr = 1'b0;
    logic       out_vld;
    logic [7:0] out_code;
    logic [7:0] out_dbm;
    logic [7:0] peak_ed;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rssi_quality_conv dut_i (
        .clk(clk), .rst_n(rst_n), .raw_rssi(raw_rssi), .mode_lqi(mode_lqi),
        .sample_vld(sample_vld), .scan_ok(scan_ok), .peak_clr(peak_clr),
        .out_vld(out_vld), .out_code(out_code), .out_dbm(out_dbm), .peak_ed(peak_ed)
    );

    // Entry: {req[3:0], mode_lqi, raw[7:0], exp_code[7:0], exp_dbm[7:0]}
    localparam int NV = 16;
    localparam logic [28:0] VEC [NV] = '{
        {4'd3, 1'b0, 8'h7F, 8'hFF, 8'h00},   // R3 above ceiling, R2 0 dBm
        {4'd2, 1'b0, 8'h00, 8'h00, 8'h81},   // R2 -127 dBm
        {4'd3, 1'b0, 8'h34, 8'h00, 8'hB5},   // R3 -75 floor
        {4'd3, 1'b0, 8'h35, 8'h05, 8'hB6},   // R3 -74
        {4'd3, 1'b0, 8'h50, 8'h8C, 8'hD1},   // R3 -47
        {4'd3, 1'b0, 8'h66, 8'hFA, 8'hE7},   // R3 -25
        {4'd3, 1'b0, 8'h67, 8'hFF, 8'hE8},   // R3 -24 ceiling
        {4'd5, 1'b1, 8'h6A, 8'hFF, 8'hEB},   // R5 -21 top
        {4'd4, 1'b1, 8'h69, 8'hFC, 8'hEA},   // R4 -22
        {4'd4, 1'b1, 8'h2A, 8'h00, 8'hAB},   // R4 -85 floor
        {4'd4, 1'b1, 8'h2B, 8'h04, 8'hAC},   // R4 -84
        {4'd4, 1'b1, 8'h40, 8'h58, 8'hC1},   // R4 -63
        {4'd4, 1'b1, 8'h10, 8'h00, 8'h91},   // R4 below floor
        {4'd5, 1'b1, 8'h7F, 8'hFF, 8'h00},   // R5 above top
        {4'd1, 1'b0, 8'h80, 8'h00, 8'h80},   // R1 invalid, energy mode
        {4'd1, 1'b1, 8'hFF, 8'h00, 8'h80}    // R1 invalid, link mode
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One strobed sample; results read half a cycle after the loading edge.
    task automatic sample(input logic m, input logic [7:0] r, input logic ok, input logic clr);
        @(negedge clk);
        mode_lqi = m; raw_rssi = r; scan_ok = ok; peak_clr = clr; sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0; peak_clr = 1'b0; scan_ok = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "out_code reset", out_code, 8'h00);
        check("R9", "out_dbm reset", out_dbm, 8'h00);
        check("R9", "out_vld reset", {7'd0, out_vld}, 8'h00);
        check("R9", "peak reset", peak_ed, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][28:25]);
            sample(VEC[i][24], VEC[i][23:16], 1'b0, 1'b0);
            check(tag, "code", out_code, VEC[i][15:8]);
            check(tag, "dbm", out_dbm, VEC[i][7:0]);
            check("R8", "vld pulse", {7'd0, out_vld}, 8'h01);
        end

        // R8: valid drops and results hold without a strobe
        @(negedge clk);
        check("R8", "vld low", {7'd0, out_vld}, 8'h00);
        check("R8", "code hold", out_code, 8'h00);
        check("R8", "dbm hold", out_dbm, 8'h80);

        // R6: peak hold rules
        sample(1'b0, 8'h50, 1'b1, 1'b0);
        check("R6", "peak first", peak_ed, 8'h8C);
        sample(1'b0, 8'h35, 1'b1, 1'b0);
        check("R6", "peak smaller kept", peak_ed, 8'h8C);
        sample(1'b0, 8'h66, 1'b0, 1'b0);
        check("R6", "peak failed scan kept", peak_ed, 8'h8C);
        sample(1'b1, 8'h7F, 1'b1, 1'b0);
        check("R6", "peak link mode kept", peak_ed, 8'h8C);
        sample(1'b0, 8'h66, 1'b1, 1'b0);
        check("R6", "peak raised", peak_ed, 8'hFA);
        sample(1'b0, 8'h80, 1'b1, 1'b0);
        check("R6", "peak invalid kept", peak_ed, 8'hFA);

        // R7: clear beats a same-cycle qualifying sample
        sample(1'b0, 8'h7F, 1'b1, 1'b1);
        check("R7", "clear priority", peak_ed, 8'h00);
        check("R3", "code beside clear", out_code, 8'hFF);
        sample(1'b0, 8'h20, 1'b1, 1'b0);
        check("R6", "zero result ignored", peak_ed, 8'h00);
        sample(1'b0, 8'h35, 1'b1, 1'b0);
        check("R6", "peak after clear", peak_ed, 8'h05);

        // R9: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9", "code mid reset", out_code, 8'h00);
        check("R9", "dbm mid reset", out_dbm, 8'h00);
        check("R9", "peak mid reset", peak_ed, 8'h00);
        rst_n = 1'b1;
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule